// File: doc/BRIEF.md
# Eight-Octant Bresenham Line Rasterizer

This block walks the integer pixel grid between two screen-space endpoints and emits one coordinate per pixel, each qualified by a valid strobe. A request is handed over with a start/ready handshake. The endpoints are captured once, and the block reports completion with a one-cycle done pulse before it accepts the next line.

Internally, an incrementing core only draws shallow lines in the first octant: the major offset climbs by one per pixel, and the minor offset climbs by at most one. A folding stage on the input takes the absolute deltas and swaps the axes so that the major delta is never smaller than the minor one. An unfolding stage on the output puts each point back on the side and in the axis order of the original line. Any direction of line can therefore be drawn.

Top module: `lineDrawer`

## Requirements
- R1: After reset, `ready` is high, and `pixValid` and `lineDone` are low.
- R2: `start` is acted on only while `ready` is high. `ready` is low in the cycle after acceptance and stays low until the block returns to idle. A `start` or an endpoint change during a line has no effect on the pixels that are emitted.
- R3: The first pixel is valid two cycles after the accepting clock edge. Later pixels follow every second cycle, with `pixValid` low in between.
- R4: A line emits max(|x1-x0|, |y1-y0|)+1 pixels. The first pixel is (x0,y0) and the last pixel is (x1,y1).
- R5: Between consecutive pixels, the major-axis coordinate moves by exactly one and the minor-axis coordinate moves by zero or one.
- R6: With M the major delta and m the minor delta, pixel i has a minor offset of floor((2*i*m + M - 1) / (2*M)).
- R7: `lineDone` is high for exactly one cycle, in the cycle after the last pixel. `ready` is high in the cycle after that.
- R8: Each axis moves toward its end coordinate, so it decreases when the end is smaller than the start. Y is the major axis only when |dy| > |dx| strictly, so a 45-degree line steps on X.
- R9: A line whose endpoints are equal emits exactly one pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Line request, taken while ready is high |
| x0 | input | COORD_W | Start point X |
| y0 | input | COORD_W | Start point Y |
| x1 | input | COORD_W | End point X |
| y1 | input | COORD_W | End point Y |
| ready | output | 1 | Idle, able to accept a line |
| xOut | output | COORD_W | Pixel X, qualified by pixValid |
| yOut | output | COORD_W | Pixel Y, qualified by pixValid |
| pixValid | output | 1 | Pixel coordinate valid |
| lineDone | output | 1 | One-cycle end-of-line pulse |

## Verification
The bench builds the block with COORD_W = 3, which gives an 8x8 grid. With this size it can draw every one of the 4096 ordered endpoint pairs. That covers every octant, both axis-tie diagonals, all zero-length and single-axis lines, and the extremes of the decision variable. Each pixel is compared against a closed-form rounding formula rather than an incremental model. On part of the lines, a spurious request with altered endpoints is applied mid-line.

// File: rtl/lineDrawPkg.sv
package lineDrawPkg;

  typedef enum logic [2:0] {
    ST_START,
    ST_PRIME,
    ST_RUN_DEC,
    ST_RUN_INC,
    ST_DONE
  } drawState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEnds;  // capture endpoints and folding choices
    logic prime;     // clear core offsets, seed decision term
    logic step;      // advance one pixel along the major axis
  } drawStrobe_t;

endpackage

// File: rtl/lineUnfold.sv
module lineUnfold #(
  parameter int COORD_W = 12
) (
  input  logic [COORD_W-1:0] base,
  input  logic [COORD_W-1:0] offset,
  input  logic               negate,
  output logic [COORD_W-1:0] coord
);

  // Place a positive core offset back on the original side of the start point
  always_comb begin
    coord = negate ? (base - offset) : (base + offset);
  end

endmodule

// File: rtl/lineDatapath.sv
module lineDatapath
  import lineDrawPkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  drawStrobe_t        strobe,
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  output logic [COORD_W-1:0] xOut,
  output logic [COORD_W-1:0] yOut,
  output logic               atEnd
);

  localparam int DIF_W = COORD_W + 3;
  localparam int PAD_W = DIF_W - COORD_W;
  localparam int AXES  = 2;

  // Input fold: absolute deltas, direction flags, axis swap
  logic               negXIn, negYIn, swapIn;
  logic [COORD_W-1:0] adx, ady, majIn, minIn;

  always_comb begin
    negXIn = (x1 < x0);
    negYIn = (y1 < y0);
    adx    = negXIn ? (x0 - x1) : (x1 - x0);
    ady    = negYIn ? (y0 - y1) : (y1 - y0);
    swapIn = (ady > adx);
    majIn  = swapIn ? ady : adx;
    minIn  = swapIn ? adx : ady;
  end

  // Captured line description
  logic [COORD_W-1:0] baseX, baseY, majLen, minLen;
  logic               negX, negY, swapAxes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseX    <= '0;
      baseY    <= '0;
      majLen   <= '0;
      minLen   <= '0;
      negX     <= 1'b0;
      negY     <= 1'b0;
      swapAxes <= 1'b0;
    end else if (strobe.loadEnds) begin
      baseX    <= x0;
      baseY    <= y0;
      majLen   <= majIn;
      minLen   <= minIn;
      negX     <= negXIn;
      negY     <= negYIn;
      swapAxes <= swapIn;
    end
  end

  // First-octant core
  logic signed [DIF_W-1:0] minS, majS, seedDif, addFlat, addDiag, dif;
  logic [COORD_W-1:0]      xCore, yCore;
  logic                    difPos;

  always_comb begin
    minS    = $signed({{PAD_W{1'b0}}, minLen});
    majS    = $signed({{PAD_W{1'b0}}, majLen});
    seedDif = (minS <<< 1) - majS;
    addFlat = (minS <<< 1);
    addDiag = (minS <<< 1) - (majS <<< 1);
    difPos  = !dif[DIF_W-1] && (dif != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xCore <= '0;
      yCore <= '0;
      dif   <= '0;
    end else if (strobe.prime) begin
      xCore <= '0;
      yCore <= '0;
      dif   <= seedDif;
    end else if (strobe.step) begin
      xCore <= xCore + 1'b1;
      if (difPos) begin
        yCore <= yCore + 1'b1;
        dif   <= dif + addDiag;
      end else begin
        dif   <= dif + addFlat;
      end
    end
  end

  assign atEnd = (xCore == majLen);

  // Output unfold, one lane per screen axis
  logic [AXES-1:0][COORD_W-1:0] baseArr, offArr, coordArr;
  logic [AXES-1:0]              negArr;

  always_comb begin
    baseArr[0] = baseX;
    baseArr[1] = baseY;
    offArr[0]  = swapAxes ? yCore : xCore;
    offArr[1]  = swapAxes ? xCore : yCore;
    negArr[0]  = negX;
    negArr[1]  = negY;
  end

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    lineUnfold #(.COORD_W(COORD_W)) i_unfold (
      .base  (baseArr[a]),
      .offset(offArr[a]),
      .negate(negArr[a]),
      .coord (coordArr[a])
    );
  end

  assign xOut = coordArr[0];
  assign yOut = coordArr[1];

  // R5: the major offset advances by exactly one per step
  p_major_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> xCore == $past(xCore) + 1'b1);

  // R5: the minor offset advances by zero or one per step
  p_minor_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (yCore == $past(yCore)) || (yCore == $past(yCore) + 1'b1));

  // R4: no step past the end, minor offset never beyond its delta
  p_step_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (xCore < majLen) && (yCore <= minLen));

endmodule

// File: rtl/lineControl.sv
module lineControl
  import lineDrawPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        atEnd,
  output drawStrobe_t strobe,
  output logic        ready,
  output logic        pixValid,
  output logic        lineDone
);

  drawState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    pixValid = 1'b0;
    lineDone = 1'b0;
    ready    = 1'b0;
    unique case (state)
      ST_START: begin
        ready = 1'b1;
        if (start) begin
          strobe.loadEnds = 1'b1;
          stateNxt        = ST_PRIME;
        end
      end
      ST_PRIME: begin
        strobe.prime = 1'b1;
        stateNxt     = ST_RUN_DEC;
      end
      ST_RUN_DEC: begin
        pixValid = 1'b1;
        stateNxt = atEnd ? ST_DONE : ST_RUN_INC;
      end
      ST_RUN_INC: begin
        strobe.step = 1'b1;
        stateNxt    = ST_RUN_DEC;
      end
      ST_DONE: begin
        lineDone = 1'b1;
        stateNxt = ST_START;
      end
      default: stateNxt = ST_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_START;
    else       state <= stateNxt;
  end

  // R1: idle shows no pixel and no completion
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !pixValid && !lineDone);

  // R2: an accepted request takes ready down in the next cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    start && ready |=> !ready);

  // R3: pixels never come in back-to-back cycles
  p_pixel_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> !pixValid);

  // R7: completion is a single pulse followed by idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> ready && !lineDone);

  // R7: the completion pulse directly follows a pixel
  p_done_after_pixel_r7: assert property (@(posedge clk) disable iff (!rstN)
    pixValid && atEnd |=> lineDone);

endmodule

// File: rtl/lineDrawer.sv
module lineDrawer
  import lineDrawPkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  output logic               ready,
  output logic [COORD_W-1:0] xOut,
  output logic [COORD_W-1:0] yOut,
  output logic               pixValid,
  output logic               lineDone
);

  drawStrobe_t strobe;
  logic        atEnd;

  lineControl i_control (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .atEnd   (atEnd),
    .strobe  (strobe),
    .ready   (ready),
    .pixValid(pixValid),
    .lineDone(lineDone)
  );

  lineDatapath #(.COORD_W(COORD_W)) i_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .x0    (x0),
    .y0    (y0),
    .x1    (x1),
    .y1    (y1),
    .xOut  (xOut),
    .yOut  (yOut),
    .atEnd (atEnd)
  );

endmodule

// File: tb/test_lineDrawer.sv
module test_lineDrawer;

  localparam int W    = 3;
  localparam int SPAN = 1 << W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0;
  logic         ready, pixValid, lineDone;
  logic [W-1:0] xOut, yOut;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  lineDrawer #(.COORD_W(W)) i_lineDrawer (
    .clk(clk), .rstN(rstN), .start(start),
    .x0(x0), .y0(y0), .x1(x1), .y1(y1),
    .ready(ready), .xOut(xOut), .yOut(yOut),
    .pixValid(pixValid), .lineDone(lineDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Draw one line and check every cycle until idle again
  task automatic runLine(input int ax, input int ay, input int bx, input int by, input bit disturb);
    int adx, ady, maj, mnr, last, pix, minOff, px, py, ex, ey;
    bit swp;
    adx  = (bx >= ax) ? bx - ax : ax - bx;
    ady  = (by >= ay) ? by - ay : ay - by;
    swp  = ady > adx;                 // R8: tie keeps X as major
    maj  = swp ? ady : adx;
    mnr  = swp ? adx : ady;
    last = 4 + 2 * maj;
    pix  = 0;
    x0 = W'(ax); y0 = W'(ay); x1 = W'(bx); y1 = W'(by);
    check(ready === 1'b1, "R2 ready before request", int'(ready), 1);
    start = 1'b1;
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      start = 1'b0;
      x0 = W'(ax); y0 = W'(ay); x1 = W'(bx); y1 = W'(by);
      if (k == 1) check(ready === 1'b0, "R2 busy after accept", int'(ready), 0);
      if (k >= 2 && k <= 1 + 2 * maj + 1 && (k % 2) == 0) begin
        // R3: pixel i appears at cycle 2+2i
        check(pixValid === 1'b1, "R3 pixel cadence", int'(pixValid), 1);
        minOff = (maj == 0) ? 0 : (2 * pix * mnr + maj - 1) / (2 * maj);  // R6
        px = swp ? minOff : pix;
        py = swp ? pix : minOff;
        ex = (bx >= ax) ? ax + px : ax - px;  // R8
        ey = (by >= ay) ? ay + py : ay - py;
        check(int'(xOut) == ex, "R6 R8 pixel x", int'(xOut), ex);
        check(int'(yOut) == ey, "R6 R8 pixel y", int'(yOut), ey);
        if (pix == 0) begin
          check(int'(xOut) == ax && int'(yOut) == ay, "R4 first pixel", int'(xOut), ax);
        end
        if (pix == maj) begin
          check(int'(xOut) == bx && int'(yOut) == by, "R4 last pixel", int'(yOut), by);
          if (maj == 0) check(1'b1, "R9 single pixel", 1, 1);
        end
        pix++;
      end else if (k < last) begin
        check(pixValid === 1'b0, "R3 R4 no pixel", int'(pixValid), 0);
      end
      if (k == last - 1) check(lineDone === 1'b1, "R7 done pulse", int'(lineDone), 1);
      else               check(lineDone === 1'b0, "R7 done single", int'(lineDone), 0);
      if (k > 1 && k < last) check(ready === 1'b0, "R2 busy during line", int'(ready), 0);
      if (k == last) check(ready === 1'b1, "R7 ready after done", int'(ready), 1);
      if (disturb && k == 3) begin
        // R2: spurious request with other endpoints while busy
        start = 1'b1;
        x0 = ~W'(ax); y0 = ~W'(ay); x1 = ~W'(bx); y1 = W'(ay);
      end
    end
    check(pix == maj + 1, "R4 R9 pixel count", pix, maj + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ready === 1'b1, "R1 reset ready", int'(ready), 1);
    check(pixValid === 1'b0, "R1 reset valid", int'(pixValid), 0);
    check(lineDone === 1'b0, "R1 reset done", int'(lineDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(ready === 1'b1 && pixValid === 1'b0, "R1 idle after reset", int'(ready), 1);
    for (int ax = 0; ax < SPAN; ax++)
      for (int ay = 0; ay < SPAN; ay++)
        for (int bx = 0; bx < SPAN; bx++)
          for (int by = 0; by < SPAN; by++)
            runLine(ax, ay, bx, by, ((ax + by) % 3) == 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule